// File: doc/BRIEF.md
# Delimited Packet Framer and Deframer

This block carries variable-length packets over a continuous stream of 80-bit link words, each paired with a data-valid bit. A transmit half turns a valid/ready payload stream into framed traffic. An opening delimiter carries the declared length and a busy-time value. The payload words follow with data-valid high, and the first of them is the packet header. A closing delimiter then carries the counted length, a 32-bit checksum and an end flag. When nothing is pending, the link carries filler words.

A receive half parses the same word stream. It hands the payload words on, marking the first one, and reports the busy time. At every closing delimiter it gives a verdict. It also reports framing violations that do not line up with a packet boundary. Both halves sit in one top module with separate link ports. A system can therefore loop the transmitter into the receiver, or place them at the two ends of a link.

Top module: `pktfrm_top`

## Requirements
- R1: During and right after reset, `tx_word` is all zeros with `tx_dv` low, `in_ready` is low, and every receive output is low or zero.
- R2: A link word with data-valid low is classified by its bits 79:76: 0x0 is filler, 0x1 is an opening delimiter, 0x2 is a closing delimiter. An opening delimiter carries the length in bits 15:0 and the busy time in bits 47:16, with all other bits zero. The transmitter emits one on the clock edge where it is idle and sees `in_valid`, taking `in_len` and `in_busy` from that cycle.
- R3: `in_ready` is high only between an opening delimiter and the last payload word. Each accepted word appears on `tx_word` with `tx_dv` high on the next edge. A cycle inside a packet with no accepted word emits a filler word.
- R4: On the edge after the word flagged `in_last` is accepted, the transmitter emits a closing delimiter. It has type 0x2, the end flag in bit 75, the checksum in bits 47:16 and the number of payload words actually sent in bits 15:0. All other bits are zero.
- R5: The checksum is the sum modulo 2^32, over every payload word, of the slices [31:0], [63:32] and the zero-extended [79:64].
- R6: The receiver presents every payload word received inside a packet on `pay_data`, with `pay_valid` one cycle after the word arrives. `pay_first` is high for the first word after an opening delimiter. `pkt_busy` holds the busy time of the last opening delimiter.
- R7: When a closing delimiter ends a packet, `pkt_done` pulses for one cycle. `err_len` is high with it if the payload count differs from the opening length or from the closing length.
- R8: `err_csum` is high with `pkt_done` when the received sum differs from the closing checksum. `pkt_ok` is high with `pkt_done` only when neither `err_len` nor `err_csum` is high.
- R9: `err_proto` pulses for three cases. The first is an opening delimiter inside a packet; the new packet then starts afresh. The second is a data-valid word outside a packet, which is dropped with no `pay_valid`. The third is a closing delimiter outside a packet, which gives no `pkt_done`.
- R10: Data-valid-low words with any type code other than 0x1 or 0x2 are ignored, inside or outside a packet.
- R11: A new opening delimiter can follow a closing delimiter on the very next word. Both packets are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload word offered to the transmitter |
| in_ready | output | 1 | Transmitter accepts the offered word |
| in_data | input | 80 | Payload word |
| in_last | input | 1 | Offered word is the last of its packet |
| in_len | input | 16 | Declared length, sampled with the first word |
| in_busy | input | 32 | Busy time, sampled with the first word |
| tx_word | output | 80 | Transmitted link word |
| tx_dv | output | 1 | Data-valid of the transmitted word |
| rx_word | input | 80 | Received link word |
| rx_dv | input | 1 | Data-valid of the received word |
| pay_valid | output | 1 | Received payload word present |
| pay_data | output | 80 | Received payload word |
| pay_first | output | 1 | Payload word is the packet's first (header) |
| pkt_busy | output | 32 | Busy time of the current packet |
| pkt_done | output | 1 | Packet closed by a closing delimiter |
| pkt_ok | output | 1 | Closed packet had no errors |
| err_len | output | 1 | Length mismatch on the closed packet |
| err_csum | output | 1 | Checksum mismatch on the closed packet |
| err_proto | output | 1 | Framing violation |

## Verification
The payload patterns set bits in the upper 16-bit slice, so a checksum that drops or mis-aligns the short slice gives a wrong closing field and a false `err_csum`. A mid-packet stall checks that filler words are neither counted nor summed; a receiver that counted them would raise `err_len`. Length errors are injected from each side separately: a wrong declared length from the transmitter, and a wrong closing length with a correct opening one. A receiver that compared against only one of the two fields misses one of these cases. Back-to-back packets, a repeated opening delimiter, a stray payload word, a stray closing delimiter and an unknown type code inside a packet cover the state handling. A design that got these wrong would leak dropped words to `pay_data`, emit a spurious `pkt_done`, or fail to restart the count.

// File: rtl/pktfrm_pkg.sv
package pktfrm_pkg;
  localparam int WORD_W = 80;
  localparam int LEN_W  = 16;
  localparam int SUM_W  = 32;

  localparam logic [3:0] KIND_FILL = 4'h0;
  localparam logic [3:0] KIND_OPEN = 4'h1;
  localparam logic [3:0] KIND_CLOSE = 4'h2;

  // field positions shared by transmitter and receiver
  localparam int KIND_HI  = 79;
  localparam int KIND_LO  = 76;
  localparam int FLAG_BIT = 75;
  localparam int SUM_LO   = 16;
  localparam int LEN_LO   = 0;

  typedef enum logic [1:0] {TX_IDLE, TX_BODY, TX_CLOSE} tx_state_t;
endpackage

// File: rtl/pktfrm_sum.sv
module pktfrm_sum #(
  parameter int W     = 80,
  parameter int SUM_W = 32
) (
  input  logic [SUM_W-1:0] acc,
  input  logic [W-1:0]     word,
  output logic [SUM_W-1:0] nxt
);
  localparam int NSL = (W + SUM_W - 1) / SUM_W;

  logic [NSL*SUM_W-1:0] padded;
  logic [SUM_W-1:0]     slice [NSL];

  always_comb begin
    padded = '0;
    padded[W-1:0] = word;
  end

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    assign slice[s] = padded[s*SUM_W +: SUM_W];
  end

  always_comb begin
    nxt = acc;
    for (int s = 0; s < NSL; s++) nxt = nxt + slice[s];
  end
endmodule

// File: rtl/pktfrm_tx.sv
module pktfrm_tx
  import pktfrm_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int LW    = LEN_W,
  parameter int SW    = SUM_W,
  parameter int BUSYW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          in_last,
  input  logic [LW-1:0] in_len,
  input  logic [BUSYW-1:0] in_busy,
  output logic [W-1:0]  tx_word,
  output logic          tx_dv
);
  tx_state_t     state;
  logic [LW-1:0] cnt;
  logic [SW-1:0] acc, acc_nxt;
  logic          take;

  pktfrm_sum #(.W(W), .SUM_W(SW)) u_sum (.acc(acc), .word(in_data), .nxt(acc_nxt));

  assign in_ready = (state == TX_BODY);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      cnt     <= '0;
      acc     <= '0;
      tx_word <= '0;
      tx_dv   <= 1'b0;
    end else begin
      tx_word <= '0;
      tx_dv   <= 1'b0;
      case (state)
        TX_IDLE: if (in_valid) begin
          tx_word[KIND_HI:KIND_LO] <= KIND_OPEN;
          tx_word[SUM_LO +: BUSYW] <= in_busy;
          tx_word[LEN_LO +: LW]    <= in_len;
          cnt   <= '0;
          acc   <= '0;
          state <= TX_BODY;
        end
        TX_BODY: if (take) begin
          tx_word <= in_data;
          tx_dv   <= 1'b1;
          cnt     <= cnt + 1'b1;
          acc     <= acc_nxt;
          if (in_last) state <= TX_CLOSE;
        end
        default: begin
          tx_word[KIND_HI:KIND_LO] <= KIND_CLOSE;
          tx_word[FLAG_BIT]        <= 1'b1;
          tx_word[SUM_LO +: SW]    <= acc;
          tx_word[LEN_LO +: LW]    <= cnt;
          state <= TX_IDLE;
        end
      endcase
    end
  end

  // R3
  tx_dv_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    tx_dv |-> $past(in_valid && in_ready));

  // R4
  close_not_followed_by_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_dv && tx_word[KIND_HI:KIND_LO] == KIND_CLOSE) |=> !tx_dv);

  // R2
  open_not_followed_by_close_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_dv && tx_word[KIND_HI:KIND_LO] == KIND_OPEN) |=>
      !(!tx_dv && tx_word[KIND_HI:KIND_LO] == KIND_CLOSE));
endmodule

// File: rtl/pktfrm_rx.sv
module pktfrm_rx
  import pktfrm_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int LW    = LEN_W,
  parameter int SW    = SUM_W,
  parameter int BUSYW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     rx_word,
  input  logic             rx_dv,
  output logic             pay_valid,
  output logic [W-1:0]     pay_data,
  output logic             pay_first,
  output logic [BUSYW-1:0] pkt_busy,
  output logic             pkt_done,
  output logic             pkt_ok,
  output logic             err_len,
  output logic             err_csum,
  output logic             err_proto
);
  logic          in_pkt;
  logic [LW-1:0] cnt, exp_len;
  logic [SW-1:0] acc, acc_nxt;
  logic [3:0]    kind;
  logic          bad_len, bad_sum;

  pktfrm_sum #(.W(W), .SUM_W(SW)) u_sum (.acc(acc), .word(rx_word), .nxt(acc_nxt));

  assign kind    = rx_word[KIND_HI:KIND_LO];
  assign bad_len = (cnt != exp_len) || (cnt != rx_word[LEN_LO +: LW]);
  assign bad_sum = (acc != rx_word[SUM_LO +: SW]);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt    <= 1'b0;
      cnt       <= '0;
      exp_len   <= '0;
      acc       <= '0;
      pay_valid <= 1'b0;
      pay_data  <= '0;
      pay_first <= 1'b0;
      pkt_busy  <= '0;
      pkt_done  <= 1'b0;
      pkt_ok    <= 1'b0;
      err_len   <= 1'b0;
      err_csum  <= 1'b0;
      err_proto <= 1'b0;
    end else begin
      pay_valid <= 1'b0;
      pay_first <= 1'b0;
      pkt_done  <= 1'b0;
      pkt_ok    <= 1'b0;
      err_len   <= 1'b0;
      err_csum  <= 1'b0;
      err_proto <= 1'b0;
      if (rx_dv) begin
        if (in_pkt) begin
          pay_valid <= 1'b1;
          pay_data  <= rx_word;
          pay_first <= (cnt == '0);
          cnt       <= cnt + 1'b1;
          acc       <= acc_nxt;
        end else begin
          err_proto <= 1'b1;
        end
      end else if (kind == KIND_OPEN) begin
        err_proto <= in_pkt;
        in_pkt    <= 1'b1;
        cnt       <= '0;
        acc       <= '0;
        exp_len   <= rx_word[LEN_LO +: LW];
        pkt_busy  <= rx_word[SUM_LO +: BUSYW];
      end else if (kind == KIND_CLOSE) begin
        if (in_pkt) begin
          pkt_done <= 1'b1;
          err_len  <= bad_len;
          err_csum <= bad_sum;
          pkt_ok   <= !bad_len && !bad_sum;
          in_pkt   <= 1'b0;
        end else begin
          err_proto <= 1'b1;
        end
      end
    end
  end

  // R6
  pay_from_dv_word_chk: assert property (@(posedge clk) disable iff (rst)
    pay_valid |-> $past(rx_dv));

  // R7
  done_after_close_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> $past(!rx_dv && rx_word[KIND_HI:KIND_LO] == KIND_CLOSE));

  // R8
  ok_excludes_errors_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_ok |-> (pkt_done && !err_len && !err_csum));

  // R9
  no_pay_on_stray_chk: assert property (@(posedge clk) disable iff (rst)
    (err_proto && $past(rx_dv)) |-> !pay_valid);
endmodule

// File: rtl/pktfrm_top.sv
module pktfrm_top
  import pktfrm_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int LW    = LEN_W,
  parameter int SW    = SUM_W,
  parameter int BUSYW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  input  logic             in_last,
  input  logic [LW-1:0]    in_len,
  input  logic [BUSYW-1:0] in_busy,
  output logic [W-1:0]     tx_word,
  output logic             tx_dv,
  input  logic [W-1:0]     rx_word,
  input  logic             rx_dv,
  output logic             pay_valid,
  output logic [W-1:0]     pay_data,
  output logic             pay_first,
  output logic [BUSYW-1:0] pkt_busy,
  output logic             pkt_done,
  output logic             pkt_ok,
  output logic             err_len,
  output logic             err_csum,
  output logic             err_proto
);
  pktfrm_tx #(.W(W), .LW(LW), .SW(SW), .BUSYW(BUSYW)) u_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_len(in_len), .in_busy(in_busy),
    .tx_word(tx_word), .tx_dv(tx_dv));

  pktfrm_rx #(.W(W), .LW(LW), .SW(SW), .BUSYW(BUSYW)) u_rx (
    .clk(clk), .rst(rst), .rx_word(rx_word), .rx_dv(rx_dv),
    .pay_valid(pay_valid), .pay_data(pay_data), .pay_first(pay_first),
    .pkt_busy(pkt_busy), .pkt_done(pkt_done), .pkt_ok(pkt_ok),
    .err_len(err_len), .err_csum(err_csum), .err_proto(err_proto));
endmodule

// File: tb/pktfrm_top_tb_top.sv
module pktfrm_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [79:0] in_data = '0;
  logic [15:0] in_len = '0;
  logic [31:0] in_busy = '0;
  logic in_ready;
  logic [79:0] tx_word, pay_data;
  logic tx_dv, pay_valid, pay_first, pkt_done, pkt_ok, err_len, err_csum, err_proto;
  logic [31:0] pkt_busy;
  logic inj = 1'b0, inj_dv = 1'b0;
  logic [79:0] inj_word = '0;
  logic [79:0] rx_word;
  logic rx_dv;

  assign rx_word = inj ? inj_word : tx_word;
  assign rx_dv   = inj ? inj_dv : tx_dv;

  always #10 clk = ~clk;

  pktfrm_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_len(in_len), .in_busy(in_busy), .tx_word(tx_word), .tx_dv(tx_dv),
    .rx_word(rx_word), .rx_dv(rx_dv), .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_first(pay_first), .pkt_busy(pkt_busy), .pkt_done(pkt_done), .pkt_ok(pkt_ok),
    .err_len(err_len), .err_csum(err_csum), .err_proto(err_proto));

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  // recorders, sampled on the falling edge
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  logic [80:0] txl [0:255];
  int txc [0:255];
  int txn = 0;
  logic [80:0] pl [0:255];
  int pn = 0;
  logic [2:0] dl [0:63];
  logic [31:0] dbusy [0:63];
  int dn = 0, proto_n = 0;

  always @(negedge clk) if (!rst) begin
    if (tx_dv || tx_word[79:76] != 4'h0) begin
      txl[txn] = {tx_dv, tx_word}; txc[txn] = cyc; txn++;
    end
    if (pay_valid) begin pl[pn] = {pay_first, pay_data}; pn++; end
    if (pkt_done) begin dl[dn] = {pkt_ok, err_len, err_csum}; dbusy[dn] = pkt_busy; dn++; end
    if (err_proto) proto_n++;
  end

  task automatic chk(input bit ok, input string tag, input logic [80:0] act, input logic [80:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [79:0] pat(input int k, input int i);
    return {4'hF, 12'(k), 32'hC0DE_0000 + 32'(i), 32'h8000_0001 * 32'(i + 1)};
  endfunction

  function automatic logic [31:0] wsum(input logic [31:0] a, input logic [79:0] w);
    return a + w[31:0] + w[63:32] + {16'h0, w[79:64]};
  endfunction

  function automatic logic [79:0] mk_open(input logic [15:0] l, input logic [31:0] b);
    return {4'h1, 28'h0, b, l};
  endfunction

  function automatic logic [79:0] mk_close(input logic [15:0] l, input logic [31:0] s);
    return {4'h2, 1'b1, 27'h0, s, l};
  endfunction

  function automatic logic [31:0] psum(input int k, input int n);
    logic [31:0] s = '0;
    for (int i = 0; i < n; i++) s = wsum(s, pat(k, i));
    return s;
  endfunction

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send_pkt(input int n, input int dlen, input int k, input bit gap);
    int i = 0;
    bit acc;
    in_len = 16'(dlen); in_busy = 32'hB000_0000 | 32'(k);
    in_valid = 1'b1; in_data = pat(k, 0); in_last = (n == 1);
    while (i < n) begin
      acc = in_valid && in_ready;
      tick(1);
      if (acc) begin
        i++;
        if (i < n) begin
          if (gap && i == 1) begin in_valid = 1'b0; tick(2); end
          in_valid = 1'b1; in_data = pat(k, i); in_last = (i == n - 1);
        end else begin
          in_valid = 1'b0; in_last = 1'b0;
        end
      end
    end
  endtask

  task automatic put(input logic [79:0] w, input logic d);
    inj = 1'b1; inj_word = w; inj_dv = d; tick(1);
  endtask

  task automatic put_end();
    inj_word = '0; inj_dv = 1'b0; tick(2); inj = 1'b0;
  endtask

  task automatic t_reset();
    chk(tx_word == '0 && !tx_dv, "R1 tx idle after reset", {tx_dv, tx_word}, '0);
    chk(!in_ready, "R1 in_ready low", 81'(in_ready), '0);
    chk({pay_valid, pay_first, pkt_done, pkt_ok, err_len, err_csum, err_proto} == '0 &&
        pkt_busy == '0 && pay_data == '0, "R1 rx outputs idle",
        81'({pay_valid, pkt_done, err_proto}), '0);
  endtask

  task automatic t_single();
    int t0 = txn, p0 = pn, d0 = dn;
    logic [31:0] s = psum(1, 3);
    send_pkt(3, 3, 1, 1'b1);
    tick(4);
    chk(txl[t0] == {1'b0, mk_open(16'd3, 32'hB000_0001)}, "R2 opening delimiter", txl[t0], {1'b0, mk_open(16'd3, 32'hB000_0001)});
    for (int i = 0; i < 3; i++)
      chk(txl[t0+1+i] == {1'b1, pat(1, i)}, "R3 payload on link", txl[t0+1+i], {1'b1, pat(1, i)});
    chk(txc[t0+2] == txc[t0+1] + 3, "R3 stall gives filler words", 81'(txc[t0+2] - txc[t0+1]), 81'(3));
    chk(txl[t0+4] == {1'b0, mk_close(16'd3, s)}, "R4 R5 closing delimiter", txl[t0+4], {1'b0, mk_close(16'd3, s)});
    chk(pn == p0 + 3, "R6 payload count", 81'(pn - p0), 81'(3));
    for (int i = 0; i < 3; i++)
      chk(pl[p0+i] == {i == 0, pat(1, i)}, "R6 payload and first flag", pl[p0+i], {i == 0, pat(1, i)});
    chk(dn == d0 + 1 && dl[d0] == 3'b100, "R7 R8 packet ok", 81'(dl[d0]), 81'(3'b100));
    chk(dbusy[d0] == 32'hB000_0001, "R6 busy time", 81'(dbusy[d0]), 81'(32'hB000_0001));
  endtask

  task automatic t_b2b();
    int t0 = txn, d0 = dn;
    send_pkt(2, 2, 2, 1'b0);
    send_pkt(1, 1, 3, 1'b0);
    tick(4);
    chk(txl[t0+4] == {1'b0, mk_open(16'd1, 32'hB000_0003)}, "R11 second opening", txl[t0+4], {1'b0, mk_open(16'd1, 32'hB000_0003)});
    chk(txc[t0+4] == txc[t0+3] + 1, "R11 open right after close", 81'(txc[t0+4] - txc[t0+3]), 81'(1));
    chk(dn == d0 + 2 && dl[d0] == 3'b100 && dl[d0+1] == 3'b100, "R11 both packets ok",
        81'({dl[d0], dl[d0+1]}), 81'(6'b100100));
  endtask

  task automatic t_len_tx();
    int t0 = txn, d0 = dn;
    send_pkt(2, 5, 4, 1'b0);
    tick(4);
    chk(txl[t0+3][15:0] == 16'd2, "R4 close carries sent count", 81'(txl[t0+3][15:0]), 81'(2));
    chk(dn == d0 + 1 && dl[d0] == 3'b010, "R7 opening length mismatch", 81'(dl[d0]), 81'(3'b010));
  endtask

  task automatic t_len_close();
    int d0 = dn;
    put(mk_open(16'd2, 32'h1), 1'b0);
    put(pat(5, 0), 1'b1); put(pat(5, 1), 1'b1);
    put(mk_close(16'd3, psum(5, 2)), 1'b0);
    put_end();
    chk(dn == d0 + 1 && dl[d0] == 3'b010, "R7 closing length mismatch", 81'(dl[d0]), 81'(3'b010));
  endtask

  task automatic t_csum();
    int d0 = dn;
    put(mk_open(16'd2, 32'h2), 1'b0);
    put(pat(6, 0), 1'b1); put(pat(6, 1), 1'b1);
    put(mk_close(16'd2, psum(6, 2) ^ 32'h0001_0000), 1'b0);
    put_end();
    chk(dn == d0 + 1 && dl[d0] == 3'b001, "R8 checksum error", 81'(dl[d0]), 81'(3'b001));
  endtask

  task automatic t_proto();
    int d0 = dn, p0 = pn, q0 = proto_n;
    put(pat(7, 0), 1'b1);
    put_end();
    chk(proto_n == q0 + 1 && pn == p0, "R9 stray payload dropped", 81'({proto_n - q0, pn - p0}), 81'({32'd1, 32'd0}));
    q0 = proto_n;
    put(mk_close(16'd0, 32'h0), 1'b0);
    put_end();
    chk(proto_n == q0 + 1 && dn == d0, "R9 stray close no done", 81'({proto_n - q0, dn - d0}), 81'({32'd1, 32'd0}));
    q0 = proto_n; p0 = pn;
    put(mk_open(16'd4, 32'h3), 1'b0);
    put(pat(8, 9), 1'b1);
    put(mk_open(16'd1, 32'h4), 1'b0);
    put(pat(8, 0), 1'b1);
    put(mk_close(16'd1, psum(8, 1)), 1'b0);
    put_end();
    chk(proto_n == q0 + 1, "R9 reopen flagged", 81'(proto_n - q0), 81'(1));
    chk(dn == d0 + 1 && dl[d0] == 3'b100 && pl[p0+1] == {1'b1, pat(8, 0)}, "R9 restarted packet ok",
        81'(dl[d0]), 81'(3'b100));
  endtask

  task automatic t_unknown();
    int d0 = dn, p0 = pn, q0 = proto_n;
    put({4'h7, 76'h5}, 1'b0);
    put(mk_open(16'd2, 32'h5), 1'b0);
    put(pat(9, 0), 1'b1);
    put({4'hE, 76'h123}, 1'b0);
    put(pat(9, 1), 1'b1);
    put(mk_close(16'd2, psum(9, 2)), 1'b0);
    put_end();
    chk(dn == d0 + 1 && dl[d0] == 3'b100 && pn == p0 + 2 && proto_n == q0,
        "R10 unknown codes ignored", 81'({dl[d0], pn - p0}), 81'({3'b100, 32'd2}));
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_single();
    t_b2b();
    t_len_tx();
    t_len_close();
    t_csum();
    t_proto();
    t_unknown();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule